// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Slot

This block is the bus interface for one device on a backplane where interrupt priority comes from a daisy chain. It keeps a done flag. The device sets the flag when it needs service, and the flag drives the shared, wire-ORed interrupt request. A clear strobe that carries this device's channel number removes the flag. A 16-bit mask is broadcast to every slot, and each slot keeps the one bit that a parameter selects. When that bit is set, the slot holds its request off the line. A parameter lets a slot ignore the mask altogether.

During an acknowledge cycle, the acknowledge enters at `ack_i` and leaves at `ack_o` toward the next slot, which is farther from the CPU. A slot that is actively requesting holds the acknowledge back from the slots behind it. It also enables its channel number onto the data lines, zero-extended to 16 bits. A slot with no active request passes the acknowledge through with no register in the path. When no slot responds, every slot drives zero, so the data lines read zero. Slot instances are chained output to input, and the slot nearest the CPU wins.

Top module: `irq_chain_slot`

## Requirements
- R1: After an active-low reset, the done flag and the stored mask bit are clear, `irq_o` and `data_oe_o` are 0, and `data_o` is 0.
- R2: A pulse on `set_done_i` sets the done flag at the next clock edge. With the slot unmasked, `irq_o` is 1 from that edge on.
- R3: When `clr_stb_i` is high and `clr_chan_i` equals the slot's channel, the done flag clears at the next edge. A strobe carrying any other channel has no effect. If set and a matching clear arrive in the same cycle, the set wins.
- R4: A slot with no active request drives `ack_o` equal to `ack_i` within the same cycle.
- R5: A slot whose request is active drives `ack_o` low, whatever the value of `ack_i`.
- R6: While `ack_i` is high and the request is active, `data_oe_o` is 1 and `data_o` holds the 6-bit channel in bits 5:0, with bits 15:6 at zero. In every other case, `data_oe_o` and `data_o` are 0.
- R7: When several chained slots request at once, only the slot nearest the acknowledge source responds.
- R8: A pulse on `mask_ld_i` stores `mask_i[MASK_BIT]`. With `USE_MASK`=1 and the stored bit set, `irq_o` is 0, the acknowledge passes through, and the slot does not respond.
- R9: A pending request that the mask holds off is kept. It appears on `irq_o` once a later mask load clears the bit.
- R10: With `USE_MASK`=0, the mask has no effect on the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_done_i | input | 1 | Device raises its done flag |
| clr_stb_i | input | 1 | Clear strobe |
| clr_chan_i | input | 6 | Channel that the clear strobe addresses |
| mask_ld_i | input | 1 | Mask broadcast strobe |
| mask_i | input | 16 | Broadcast mask word |
| ack_i | input | 1 | Acknowledge arriving from the CPU side |
| ack_o | output | 1 | Acknowledge passed to the next slot |
| irq_o | output | 1 | Contribution to the shared request line |
| data_oe_o | output | 1 | Data bus output enable |
| data_o | output | 16 | Zero-extended channel number, or zero when not responding |

## Verification
The bench chains three slots. The first, channel 5, is masked by bit 3. The second, channel 17, is masked by bit 9. The third, channel 42, is built with `USE_MASK`=0. Because the three requesters overlap, the bench can watch the winner move down the chain as each nearer slot is cleared. Mask words that hit one slot and not the others show that a masked slot keeps its pending request and passes the acknowledge on, and that the slot built without the mask ignores it.

// File: rtl/irq_slot_pkg.sv
package irq_slot_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned MASK_W = 16;
  localparam int unsigned CHAN_W = 6;
  typedef logic [CHAN_W-1:0] chan_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [MASK_W-1:0] mask_t;
endpackage

// File: rtl/irq_done_flag.sv
module irq_done_flag
  import irq_slot_pkg::*;
#(
  parameter chan_t CHAN = chan_t'(1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  set_i,
  input  logic  clr_stb_i,
  input  chan_t clr_chan_i,
  output logic  done_o
);
  logic clr_hit;
  assign clr_hit = clr_stb_i && (clr_chan_i == CHAN);

  // set has priority so an event arriving with the clear is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      done_o <= 1'b0;
    else if (set_i)   done_o <= 1'b1;
    else if (clr_hit) done_o <= 1'b0;
  end

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> done_o); // R2
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_stb_i && clr_chan_i == CHAN && !set_i) |=> !done_o); // R3
  AST_CLR_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(clr_stb_i && clr_chan_i == CHAN)) |=> done_o); // R3
endmodule

// File: rtl/irq_mask_latch.sv
module irq_mask_latch
  import irq_slot_pkg::*;
#(
  parameter int unsigned MASK_BIT = 0,
  parameter bit          USE_MASK = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_i,
  input  mask_t mask_i,
  output logic  masked_o
);
  logic unused_mask;
  assign unused_mask = ^mask_i;

  if (USE_MASK) begin : g_mask
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bit_q <= 1'b0;
      else if (ld_i) bit_q <= mask_i[MASK_BIT];
    end
    assign masked_o = bit_q;

    AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i |=> (masked_o == $past(mask_i[MASK_BIT]))); // R8
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_i |=> $stable(masked_o)); // R9
  end else begin : g_nomask
    logic unused_ctl;
    assign unused_ctl = ld_i ^ clk_i ^ rst_ni;
    assign masked_o   = 1'b0;
  end
endmodule

// File: rtl/irq_ack_gate.sv
module irq_ack_gate
  import irq_slot_pkg::*;
#(
  parameter chan_t CHAN = chan_t'(1)
) (
  input  logic  req_i,
  input  logic  ack_i,
  output logic  ack_o,
  output logic  oe_o,
  output data_t data_o
);
  localparam int unsigned PAD_W = DATA_W - CHAN_W;
  localparam data_t CHAN_WORD = {{PAD_W{1'b0}}, CHAN};

  always_comb begin
    ack_o  = ack_i & ~req_i;
    oe_o   = ack_i & req_i;
    data_o = oe_o ? CHAN_WORD : '0;
  end
endmodule

// File: rtl/irq_chain_slot.sv
module irq_chain_slot
  import irq_slot_pkg::*;
#(
  parameter chan_t       CHAN     = chan_t'(1),
  parameter int unsigned MASK_BIT = 0,
  parameter bit          USE_MASK = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_done_i,
  input  logic        clr_stb_i,
  input  logic [5:0]  clr_chan_i,
  input  logic        mask_ld_i,
  input  logic [15:0] mask_i,
  input  logic        ack_i,
  output logic        ack_o,
  output logic        irq_o,
  output logic        data_oe_o,
  output logic [15:0] data_o
);
  logic done_q;
  logic masked_q;

  irq_done_flag #(.CHAN(CHAN)) u_done (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_done_i),
    .clr_stb_i  (clr_stb_i),
    .clr_chan_i (clr_chan_i),
    .done_o     (done_q)
  );

  irq_mask_latch #(.MASK_BIT(MASK_BIT), .USE_MASK(USE_MASK)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (mask_ld_i),
    .mask_i   (mask_i),
    .masked_o (masked_q)
  );

  // masked requests stay pending in done_q but leave the line alone
  assign irq_o = done_q & ~masked_q;

  irq_ack_gate #(.CHAN(CHAN)) u_gate (
    .req_i  (irq_o),
    .ack_i  (ack_i),
    .ack_o  (ack_o),
    .oe_o   (data_oe_o),
    .data_o (data_o)
  );

  AST_ACK_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !ack_o); // R5
  AST_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (ack_i && !ack_o)); // R6
  AST_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == 16'h0000)); // R6
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_q |-> (!irq_o && !data_oe_o)); // R8
  AST_PASS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> (ack_o == ack_i)); // R4
endmodule

// File: tb/tb_irq_chain_slot.sv
`timescale 1ns/1ps
module tb_irq_chain_slot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  set_v = '0;
  logic        clr = 1'b0;
  logic [5:0]  clr_ch = '0;
  logic        ld = 1'b0;
  logic [15:0] mask = '0;
  logic        ack = 1'b0;
  logic [2:0]  ack_out, irq, oe;
  logic [15:0] d0, d1, d2;

  always #4 clk = ~clk;

  irq_chain_slot #(.CHAN(6'd5), .MASK_BIT(3), .USE_MASK(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .set_done_i(set_v[0]), .clr_stb_i(clr),
    .clr_chan_i(clr_ch), .mask_ld_i(ld), .mask_i(mask), .ack_i(ack),
    .ack_o(ack_out[0]), .irq_o(irq[0]), .data_oe_o(oe[0]), .data_o(d0));
  irq_chain_slot #(.CHAN(6'd17), .MASK_BIT(9), .USE_MASK(1'b1)) u_s1 (
    .clk_i(clk), .rst_ni(rst_n), .set_done_i(set_v[1]), .clr_stb_i(clr),
    .clr_chan_i(clr_ch), .mask_ld_i(ld), .mask_i(mask), .ack_i(ack_out[0]),
    .ack_o(ack_out[1]), .irq_o(irq[1]), .data_oe_o(oe[1]), .data_o(d1));
  irq_chain_slot #(.CHAN(6'd42), .MASK_BIT(0), .USE_MASK(1'b0)) u_s2 (
    .clk_i(clk), .rst_ni(rst_n), .set_done_i(set_v[2]), .clr_stb_i(clr),
    .clr_chan_i(clr_ch), .mask_ld_i(ld), .mask_i(mask), .ack_i(ack_out[1]),
    .ack_o(ack_out[2]), .irq_o(irq[2]), .data_oe_o(oe[2]), .data_o(d2));

  typedef struct {
    logic        irq;
    logic        ack_end;
    logic [15:0] data;
    logic [2:0]  oe;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done_run = 1'b0;

  task automatic push(input logic e_irq, input logic e_ack, input logic [15:0] e_d,
                      input logic [2:0] e_oe, input string tag);
    exp_t e;
    e.irq = e_irq; e.ack_end = e_ack; e.data = e_d; e.oe = e_oe; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic step(input logic [2:0] s, input logic c, input logic [5:0] cc,
                      input logic l, input logic [15:0] m, input logic a,
                      input logic e_irq, input logic e_ack, input logic [15:0] e_d,
                      input logic [2:0] e_oe, input string tag);
    @(posedge clk); #2;
    set_v = s; clr = c; clr_ch = cc; ld = l; mask = m; ack = a;
    @(posedge clk); #1;
    set_v = '0; clr = 1'b0; ld = 1'b0;
    push(e_irq, e_ack, e_d, e_oe, tag);
  endtask

  // monitor: compare wired-OR bus view against scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        logic        a_irq;
        logic [15:0] a_d;
        e = sb_q.pop_front();
        a_irq = |irq;
        a_d = d0 | d1 | d2;
        n_vec++;
        if (a_irq !== e.irq || ack_out[2] !== e.ack_end || a_d !== e.data || oe !== e.oe) begin
          n_bad++;
          $display("FAIL %s: irq=%b ack_end=%b data=%h oe=%b expected irq=%b ack_end=%b data=%h oe=%b",
                   e.tag, a_irq, ack_out[2], a_d, oe, e.irq, e.ack_end, e.data, e.oe);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done_run) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 push(1'b0, 1'b0, 16'h0000, 3'b000, "R1 reset idle");
    @(negedge clk); @(posedge clk); #1 rst_n = 1'b1;
    step(3'b000, 0, 0, 0, 0, 1, 0, 1, 16'h0000, 3'b000, "R4 ack passes empty chain");
    step(3'b100, 0, 0, 0, 0, 1, 1, 0, 16'd42, 3'b100, "R2 R5 R6 far slot answers");
    step(3'b010, 0, 0, 0, 0, 1, 1, 0, 16'd17, 3'b010, "R7 R4 middle slot wins");
    step(3'b001, 0, 0, 0, 0, 1, 1, 0, 16'd5, 3'b001, "R7 nearest slot wins");
    step(3'b000, 0, 0, 0, 0, 0, 1, 0, 16'h0000, 3'b000, "R6 no ack no drive");
    step(3'b000, 1, 6'd5, 0, 0, 1, 1, 0, 16'd17, 3'b010, "R3 clear ch5");
    step(3'b000, 1, 6'd33, 0, 0, 1, 1, 0, 16'd17, 3'b010, "R3 clear other channel ignored");
    step(3'b000, 1, 6'd17, 0, 0, 1, 1, 0, 16'd42, 3'b100, "R3 clear ch17");
    step(3'b000, 1, 6'd42, 0, 0, 1, 0, 1, 16'h0000, 3'b000, "R3 clear ch42");
    step(3'b101, 0, 0, 1, 16'h0009, 1, 1, 0, 16'd42, 3'b100, "R8 R10 masked slot passes ack");
    step(3'b000, 0, 0, 1, 16'h0000, 1, 1, 0, 16'd5, 3'b001, "R9 unmask releases pending");
    step(3'b010, 0, 0, 1, 16'h0200, 1, 1, 0, 16'd5, 3'b001, "R8 mask middle slot");
    step(3'b000, 1, 6'd5, 0, 0, 1, 1, 0, 16'd42, 3'b100, "R8 masked middle skipped");
    step(3'b000, 1, 6'd42, 0, 0, 1, 0, 1, 16'h0000, 3'b000, "R9 masked pending hidden");
    step(3'b000, 0, 0, 1, 16'h0000, 1, 1, 0, 16'd17, 3'b010, "R9 pending reappears");
    step(3'b001, 1, 6'd5, 0, 0, 1, 1, 0, 16'd5, 3'b001, "R3 set beats clear");
    step(3'b000, 1, 6'd5, 0, 0, 1, 1, 0, 16'd17, 3'b010, "R3 clear ch5 again");
    step(3'b000, 1, 6'd17, 0, 0, 1, 0, 1, 16'h0000, 3'b000, "R4 chain idle at end");
    repeat (3) @(posedge clk);
    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule